// File: doc/BRIEF.md
# Pulse-Response Superposition Channel Emulator

This block stands in for a lossy, linear, terminated serial link inside an all-digital simulation or test chip. A serial bit stream goes in; a signed 11-bit code stream comes out that follows the waveform a receiver would see at its input. The block holds a stored single-bit pulse response that spans five bit periods. Every transmitted bit adds that response, or its negation, to the output, shifted in time by the bit's position. The sum is then delayed by a programmable time of flight.

One bit period is `SPB` sample clocks. The default of 200 gives 10 ps steps for a 2 ns bit. Software loads the response table through a simple write port while no stream is running. It then strobes bits in once per bit period. Each output sample is the sign-weighted sum of five table entries, one from each of the five most recent bit slots. The entries sit `SPB` apart in the table.

Top module: `chan_emu`

## Requirements
- R1: After a synchronous active-low reset, `rx_valid` and `rx_sample` are 0 and the block is idle.
- R2: When the block is idle, a `bit_valid` strobe starts a stream and that bit becomes step 0 of a bit period. While a stream runs, a new bit is taken only in the cycle after step `SPB-1`. A `bit_valid` strobe at any other step is ignored.
- R3: At step k, the output before delay is the sum over slot j (0 = newest) of w_j·PR[k + SPB·j]. The weight w_j is +1 for a transmitted 1 and −1 for a transmitted 0.
- R4: A history slot that no bit has filled contributes zero, so the first bits of a stream are not summed against phantom zeros.
- R5: If no `bit_valid` arrives at a bit boundary, an empty slot enters the history. The tails of earlier bits keep playing out, and the stream ends once all five slots are empty.
- R6: The sum uses `ACC_W`-bit (default 14) two's-complement arithmetic and is clipped to the range −1024..1023.
- R7: The sample for step k of a bit accepted at clock edge e appears on `rx_sample` after edge e + 2 + `flight_dly` + k.
- R8: `rx_valid` is the stream-active flag delayed by the same amount as the data, so it stays low until the delay line has filled with valid samples.
- R9: Table writes take effect only while the block is idle. A write during a stream is dropped, and the table entries outside the write address are never changed.
- R10: Reset clears the history, the step counter and the delay line, but not the table. A stream that starts after reset sees no trace of bits sent before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe offering a new transmitted bit |
| bit_in | input | 1 | Transmitted bit value |
| tbl_we | input | 1 | Pulse-response table write enable |
| tbl_addr | input | clog2(5·SPB) | Table write address (step + SPB·period) |
| tbl_data | input | 11 | Signed table entry |
| flight_dly | input | DLY_W | Time-of-flight delay in sample clocks |
| rx_sample | output | 11 | Signed receiver-input code |
| rx_valid | output | 1 | rx_sample carries a stream sample |

## Verification
The bench drives the first bit of a stream alone, with the other four slots still empty. A design that treated those slots as zeros would show the negated table summed into every sample. It sends spurious strobes in the middle of a bit period; a design that took them would shift its history early and misalign every later sample. Further tests cover zero and maximum flight delay, which expose off-by-one errors in the circular buffer pointer. A table write during a stream is checked, since it would corrupt later samples if it were accepted. All-high and all-low streams against a large table must clip rather than wrap around. A reset in the middle of a stream must not let old history or queued samples leak into the next stream.

// File: rtl/chan_emu_pkg.sv
// Shared constants and the history-slot type for the channel emulator.
package chan_emu_pkg;
    parameter int unsigned DEF_SAMP_W = 11;  // output / table code width
    parameter int unsigned DEF_ACC_W  = 14;  // accumulator width
    parameter int unsigned DEF_NTAP   = 5;   // bit periods covered by the response

    // One history slot: was a bit sent in this period, and its value.
    typedef struct packed {
        logic vld;
        logic b;
    } slot_t;
endpackage

// File: rtl/chan_emu_hist.sv
// Bit history and sub-step counter.
// Keeps the last NTAP bit slots (index 0 newest) and the step within the
// current bit period. Assumes SPB >= 2. Active while any slot holds a bit.
module chan_emu_hist
    import chan_emu_pkg::*;
#(
    parameter int SPB  = 200,
    parameter int NTAP = DEF_NTAP,
    localparam int K_W = $clog2(SPB)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_valid,
    input  logic                  bit_in,
    output slot_t [NTAP-1:0]      hist,
    output logic  [K_W-1:0]       step,
    output logic                  active
);
    logic  adv;
    slot_t nslot;

    // Stream is running while any slot still carries a transmitted bit.
    always_comb begin
        active = 1'b0;
        for (int j = 0; j < NTAP; j++) active = active | hist[j].vld;
    end

    // Bit boundary: first strobe when idle, or the end of a period when running.
    always_comb begin
        adv   = active ? (int'(step) == SPB - 1) : bit_valid;
        nslot = '{vld: bit_valid, b: bit_valid & bit_in};
    end

    // Shift the history at a boundary, otherwise count steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            step <= '0;
        end else if (adv) begin
            hist <= {hist[NTAP-2:0], nslot};
            step <= '0;
        end else if (active) begin
            step <= step + K_W'(1);
        end
    end
endmodule

// File: rtl/chan_emu_sum.sv
// Pulse-response table and sign-selected superposition.
// Holds NTAP*SPB signed entries; each cycle adds or subtracts one entry per
// filled slot, clips to the output range and registers the result.
// Assumes the table is written only while idle (writes when active are dropped).
module chan_emu_sum
    import chan_emu_pkg::*;
#(
    parameter int SPB    = 200,
    parameter int NTAP   = DEF_NTAP,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int ACC_W  = DEF_ACC_W,
    localparam int DEPTH = SPB * NTAP,
    localparam int TA_W  = $clog2(DEPTH),
    localparam int K_W   = $clog2(SPB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [TA_W-1:0]          tbl_addr,
    input  logic signed [SAMP_W-1:0] tbl_data,
    input  logic                     active,
    input  slot_t [NTAP-1:0]         hist,
    input  logic [K_W-1:0]           step,
    output logic signed [ACC_W-1:0]  acc,
    output logic signed [SAMP_W-1:0] samp,
    output logic                     samp_vld
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 <<< (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

    logic signed [SAMP_W-1:0] pr [DEPTH];
    logic signed [SAMP_W-1:0] sat;

    // Table load, gated off while a stream runs.
    always_ff @(posedge clk) begin
        if (tbl_we && !active && int'(tbl_addr) < DEPTH)
            pr[tbl_addr] <= tbl_data;
    end

    // Sum of signed table entries, one per filled slot.
    always_comb begin
        logic signed [SAMP_W-1:0] tap;
        logic signed [ACC_W-1:0]  term;
        acc = '0;
        for (int j = 0; j < NTAP; j++) begin
            tap  = pr[TA_W'(int'(step) + SPB * j)];
            term = {{(ACC_W - SAMP_W){tap[SAMP_W-1]}}, tap};
            if (hist[j].vld) acc = hist[j].b ? acc + term : acc - term;
        end
    end

    // Clip to the signed output range.
    always_comb begin
        if (acc > HI)      sat = HI[SAMP_W-1:0];
        else if (acc < LO) sat = LO[SAMP_W-1:0];
        else               sat = acc[SAMP_W-1:0];
    end

    // Register the clipped sample and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp     <= '0;
            samp_vld <= 1'b0;
        end else begin
            samp     <= sat;
            samp_vld <= active;
        end
    end
endmodule

// File: rtl/chan_emu_flight.sv
// Time-of-flight delay line.
// Circular buffer of 2**DLY_W entries carrying sample and valid together;
// output lags the input by dly+1 clocks. dly must stay constant during a stream.
module chan_emu_flight #(
    parameter int SAMP_W = 11,
    parameter int DLY_W  = 10,
    localparam int DEPTH = 1 << DLY_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DLY_W-1:0]         dly,
    input  logic signed [SAMP_W-1:0] samp,
    input  logic                     samp_vld,
    output logic signed [SAMP_W-1:0] rx_sample,
    output logic                     rx_valid
);
    logic [SAMP_W:0]    dly_mem [DEPTH];
    logic [DLY_W-1:0]   wp;
    logic [SAMP_W:0]    out_q;

    // Write every cycle, read the entry written dly cycles earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) dly_mem[i] <= '0;
            wp    <= '0;
            out_q <= '0;
        end else begin
            dly_mem[wp] <= {samp_vld, samp};
            wp          <= wp + DLY_W'(1);
            out_q       <= (dly == '0) ? {samp_vld, samp} : dly_mem[wp - dly];
        end
    end

    // Split the stored word into the output ports.
    always_comb begin
        rx_sample = out_q[SAMP_W-1:0];
        rx_valid  = out_q[SAMP_W];
    end
endmodule

// File: rtl/chan_emu.sv
// Channel emulator top: history -> superposition -> flight delay.
// Latency from bit acceptance to its step-0 sample is 2 + flight_dly clocks.
module chan_emu
    import chan_emu_pkg::*;
#(
    parameter int SPB    = 200,
    parameter int NTAP   = DEF_NTAP,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int DLY_W  = 10,
    localparam int TA_W  = $clog2(SPB * NTAP),
    localparam int K_W   = $clog2(SPB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_valid,
    input  logic                     bit_in,
    input  logic                     tbl_we,
    input  logic [TA_W-1:0]          tbl_addr,
    input  logic signed [SAMP_W-1:0] tbl_data,
    input  logic [DLY_W-1:0]         flight_dly,
    output logic signed [SAMP_W-1:0] rx_sample,
    output logic                     rx_valid
);
    slot_t [NTAP-1:0]         hist_s;
    logic  [K_W-1:0]          step_s;
    logic                     active_s;
    logic signed [ACC_W-1:0]  acc_s;
    logic signed [SAMP_W-1:0] samp_s;
    logic                     samp_vld_s;

    chan_emu_hist #(.SPB(SPB), .NTAP(NTAP)) u_hist (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .hist(hist_s), .step(step_s), .active(active_s)
    );

    chan_emu_sum #(.SPB(SPB), .NTAP(NTAP), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .active(active_s), .hist(hist_s), .step(step_s),
        .acc(acc_s), .samp(samp_s), .samp_vld(samp_vld_s)
    );

    chan_emu_flight #(.SAMP_W(SAMP_W), .DLY_W(DLY_W)) u_flight (
        .clk(clk), .rst_n(rst_n), .dly(flight_dly), .samp(samp_s),
        .samp_vld(samp_vld_s), .rx_sample(rx_sample), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/chan_emu_chk.sv
// Property checker for chan_emu, bound into every instance of the top.
module chan_emu_chk
    import chan_emu_pkg::*;
#(
    parameter int SPB    = 200,
    parameter int NTAP   = DEF_NTAP,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int DLY_W  = 10,
    localparam int K_W   = $clog2(SPB)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bit_valid,
    input logic                     active,
    input slot_t [NTAP-1:0]         hist,
    input logic [K_W-1:0]           step,
    input logic signed [ACC_W-1:0]  acc,
    input logic signed [SAMP_W-1:0] samp,
    input logic                     samp_vld,
    input logic [DLY_W-1:0]         flight_dly,
    input logic                     rx_valid
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 <<< (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

    logic armed;

    // Marks cycles after the first clean post-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && active) |-> (int'(step) < SPB));

    assert_hold_mid_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && active && int'(step) != SPB - 1) |=> $stable(hist));

    assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !active && !bit_valid) |=> !active);

    assert_clip_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc > HI) |=> (samp == HI[SAMP_W-1:0]));

    assert_clip_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc < LO) |=> (samp == LO[SAMP_W-1:0]));

    assert_zero_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && flight_dly == '0) |=> (rx_valid == $past(samp_vld)));
endmodule

bind chan_emu chan_emu_chk #(
    .SPB(SPB), .NTAP(NTAP), .SAMP_W(SAMP_W), .ACC_W(ACC_W), .DLY_W(DLY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .active(active_s),
    .hist(hist_s), .step(step_s), .acc(acc_s), .samp(samp_s),
    .samp_vld(samp_vld_s), .flight_dly(flight_dly), .rx_valid(rx_valid)
);

// File: tb/chan_emu_test.sv
// Directed bench for chan_emu with a short bit period and a small delay line.
module chan_emu_test;
    localparam int SPB    = 4;
    localparam int NTAP   = 5;
    localparam int SAMP_W = 11;
    localparam int DLY_W  = 4;
    localparam int DEPTH  = SPB * NTAP;
    localparam int TA_W   = $clog2(DEPTH);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     bit_valid = 1'b0;
    logic                     bit_in = 1'b0;
    logic                     tbl_we = 1'b0;
    logic [TA_W-1:0]          tbl_addr = '0;
    logic signed [SAMP_W-1:0] tbl_data = '0;
    logic [DLY_W-1:0]         flight_dly = '0;
    logic signed [SAMP_W-1:0] rx_sample;
    logic                     rx_valid;

    int nchk = 0;
    int nbad = 0;
    int pr_m [DEPTH];
    int tx [16];
    int tx_n = 0;

    chan_emu #(.SPB(SPB), .NTAP(NTAP), .SAMP_W(SAMP_W), .DLY_W(DLY_W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .flight_dly(flight_dly), .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pre-delay sample m of the current stream, from R3/R4/R6.
    function automatic int expect_at(input int m);
        int p = m / SPB;
        int k = m % SPB;
        int s = 0;
        for (int j = 0; j < NTAP; j++) begin
            int i = p - j;
            if (i >= 0 && i < tx_n)
                s += (tx[i] != 0) ? pr_m[k + SPB * j] : -pr_m[k + SPB * j];
        end
        if (s > 1023)  s = 1023;
        if (s < -1024) s = -1024;
        return s;
    endfunction

    // Loads the table while idle; mode 0 mixed values, mode 1 large values.
    task automatic load_table(input int mode);
        for (int i = 0; i < DEPTH; i++) begin
            pr_m[i] = (mode == 0) ? ((i * 53) % 180) - 70 : 1000;
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_addr = TA_W'(i);
            tbl_data = SAMP_W'(pr_m[i]);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Sends tx[0..tx_n-1] and checks every delayed output sample and the drain.
    task automatic run_stream(input string req, input int d, input bit noise,
                              input bit midwrite);
        flight_dly = DLY_W'(d);
        fork
            begin
                for (int i = 0; i < tx_n; i++) begin
                    @(negedge clk);
                    bit_valid = 1'b1;
                    bit_in    = (tx[i] != 0);
                    @(negedge clk);
                    bit_valid = noise;
                    bit_in    = (tx[i] == 0);
                    if (midwrite && i == 1) begin
                        tbl_we   = 1'b1;
                        tbl_addr = '0;
                        tbl_data = SAMP_W'(555);
                    end
                    @(negedge clk);
                    bit_valid = 1'b0;
                    tbl_we    = 1'b0;
                    repeat (SPB - 3) @(negedge clk);
                end
            end
            begin
                @(negedge clk);
                repeat (2 + d) @(negedge clk);
                chk({req, " valid low before first sample"}, int'(rx_valid), 0);
                for (int m = 0; m < (tx_n + NTAP - 1) * SPB; m++) begin
                    @(negedge clk);
                    chk({req, " valid"}, int'(rx_valid), 1);
                    chk({req, " sample"}, int'(rx_sample), expect_at(m));
                end
                @(negedge clk);
                chk({req, " valid low after drain"}, int'(rx_valid), 0);
            end
        join
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset_state();
        chk("R1 rx_valid after reset", int'(rx_valid), 0);
        chk("R1 rx_sample after reset", int'(rx_sample), 0);
    endtask

    task automatic test_single_bit();
        tx[0] = 1; tx_n = 1;
        run_stream("R3 R4 R7 single bit, zero delay", 0, 1'b0, 1'b0);
    endtask

    task automatic test_pattern_noise();
        tx[0] = 1; tx[1] = 0; tx[2] = 0; tx[3] = 1; tx[4] = 0; tx[5] = 1; tx_n = 6;
        run_stream("R2 R3 R8 pattern with stray strobes", 3, 1'b1, 1'b0);
    endtask

    task automatic test_max_delay();
        tx[0] = 0; tx[1] = 1; tx[2] = 1; tx[3] = 0; tx[4] = 0; tx[5] = 0;
        tx[6] = 1; tx_n = 7;
        run_stream("R5 R7 R8 max delay", (1 << DLY_W) - 1, 1'b0, 1'b0);
    endtask

    task automatic test_busy_write();
        tx[0] = 1; tx[1] = 0; tx[2] = 1; tx_n = 3;
        run_stream("R9 write during stream dropped", 2, 1'b0, 1'b1);
        tx[0] = 1; tx_n = 1;
        run_stream("R9 table intact after dropped write", 0, 1'b0, 1'b0);
    endtask

    task automatic test_saturation();
        load_table(1);
        for (int i = 0; i < 6; i++) tx[i] = 1;
        tx_n = 6;
        run_stream("R6 clip high", 1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) tx[i] = 0;
        run_stream("R6 clip low", 1, 1'b0, 1'b0);
        load_table(0);
    endtask

    task automatic test_mid_reset();
        flight_dly = DLY_W'(1);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R10 valid low after mid-stream reset", int'(rx_valid), 0);
            chk("R10 sample cleared after reset", int'(rx_sample), 0);
        end
        tx[0] = 0; tx_n = 1;
        run_stream("R10 fresh stream after reset", 2, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        load_table(0);
        test_single_bit();
        test_pattern_noise();
        test_max_delay();
        test_busy_write();
        test_saturation();
        test_mid_reset();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule